// File: doc/BRIEF.md
# Operand Address Decoder for Mode/Register/Memory Instruction Bytes

This block watches an instruction byte stream, one byte per accepted cycle, and works out where the operands of a two-operand instruction live. Each instruction may begin with any number of segment-override prefix bytes. Next comes an opcode byte, whose two low bits give the operand width and the direction. A mode/register/register-memory byte follows it, and then zero, one or two displacement bytes. The block does not interpret the opcode beyond those two bits, and it never sees immediate data.

Once the last byte of the addressing part has been taken, the block reports three things for one cycle. The first is the register operand (its 3-bit code and width), along with whether that register is the destination. The second is whether the other operand is a register or a memory location. For a memory operand, the third is the 16-bit effective address, the chosen segment and the 20-bit physical address. The base, index and segment register values are inputs from the surrounding register file, and they are sampled in the cycle the last byte is accepted. After the report, the block waits for the next prefix or opcode.

Top module: `modrm_agu`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` is 0 and every result output is 0.
- R2: A byte of the form 001ss110, taken while waiting for an opcode, is a prefix and is not an opcode. It forces the segment of the next memory operand to ss, where 00 is the extra segment, 01 code, 10 stack and 11 data. `out_seg` uses the same 2-bit encoding.
- R3: Opcode bit 0 is reported as `out_wide`, and opcode bit 1 is reported as `out_reg_dst` (1 means the register field is the destination). Bits 5:3 of the mode byte are reported as `out_reg_code`.
- R4: When mode (bits 7:6) is 11, `out_rm_is_reg` is 1, `out_rm_code` equals bits 2:0, no displacement byte is expected, and `out_ea` and `out_pa` are 0.
- R5: For memory modes, the register-memory field picks the sum. 000 gives BX+SI and 001 gives BX+DI. 010 gives BP+SI and 011 gives BP+DI. 100 gives SI alone, 101 DI alone, 110 BP alone and 111 BX alone.
- R6: Mode 00 takes no displacement byte, except that register-memory 110 takes two bytes used as the whole address. Mode 01 takes one byte, sign-extended to 16 bits. Mode 10 takes two bytes. A two-byte displacement arrives low byte first.
- R7: Without a prefix, a memory operand whose sum includes BP uses the stack segment, and every other memory operand uses the data segment.
- R8: The effective address wraps modulo 2^16. `out_pa` equals the segment value times 16 plus the effective address, modulo 2^20.
- R9: `out_valid` pulses for exactly one cycle, in the cycle after the last addressing byte is accepted, and at no other time. Cycles with `in_valid` low change nothing.
- R10: A prefix applies only to the instruction that follows it. The next instruction without a prefix uses its default segment again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` is valid and is accepted this cycle |
| in_byte | input | 8 | Instruction stream byte |
| reg_bx | input | 16 | BX register value |
| reg_bp | input | 16 | BP register value |
| reg_si | input | 16 | SI register value |
| reg_di | input | 16 | DI register value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| out_valid | output | 1 | One-cycle result strobe |
| out_reg_code | output | 3 | Register-field operand code |
| out_wide | output | 1 | Operand width: 1 word, 0 byte |
| out_reg_dst | output | 1 | Register field is the destination |
| out_rm_is_reg | output | 1 | Second operand is a register |
| out_rm_code | output | 3 | Register-memory field |
| out_ea | output | 16 | Effective address |
| out_seg | output | 2 | Selected segment |
| out_pa | output | 20 | Physical address |

## Verification
The physical-address property compares the result against the segment inputs one cycle earlier. It therefore assumes the segment and pointer inputs stay steady while an instruction's bytes are arriving. The bench changes them only between instructions, before the first byte of the next one. The single-pulse property relies on every instruction having at least two bytes, so two reports can never fall on adjacent cycles. The stimulus always sends an opcode and a mode byte, and adds idle cycles between bytes to exercise the gaps.

// File: rtl/modrm_agu_pkg.sv
package modrm_agu_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_t;

  typedef enum logic [1:0] {
    ST_OPC,
    ST_MODRM,
    ST_DLO,
    ST_DHI
  } st_t;

  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [2:0] RM_DIRECT   = 3'b110;
endpackage

// File: rtl/modrm_classify.sv
module modrm_classify
  import modrm_agu_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [2:0] rm,
  output logic       is_reg,
  output logic [1:0] disp_n,
  output logic       use_base,
  output logic       base_bp,
  output logic       use_idx,
  output logic       idx_di,
  output seg_t       def_seg
);
  logic direct;

  always_comb begin
    is_reg   = (mode == MODE_REG);
    direct   = (mode == MODE_NODISP) && (rm == RM_DIRECT);
    // base: pairs 000-011 plus single 110/111
    use_base = !is_reg && !direct && (!rm[2] || rm[1]);
    base_bp  = rm[2] ? (rm[1:0] == 2'b10) : rm[1];
    // index: pairs 000-011 plus single 100/101
    use_idx  = !is_reg && (!rm[2] || !rm[1]);
    idx_di   = rm[0];
    def_seg  = (use_base && base_bp) ? SEG_SS : SEG_DS;
    unique case (mode)
      MODE_NODISP: disp_n = direct ? 2'd2 : 2'd0;
      MODE_DISP8:  disp_n = 2'd1;
      MODE_REG:    disp_n = 2'd0;
      default:     disp_n = 2'd2;
    endcase
  end
endmodule

// File: rtl/modrm_ea_adder.sv
module modrm_ea_adder #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = ADDR_W + SEG_SHIFT
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] seg_base,
  output logic [ADDR_W-1:0] ea,
  output logic [PA_W-1:0]   pa
);
  always_comb begin
    ea = base + index + disp;
    pa = {seg_base, {SEG_SHIFT{1'b0}}} + PA_W'(ea);
  end
endmodule

// File: rtl/modrm_agu.sv
module modrm_agu
  import modrm_agu_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = ADDR_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [ADDR_W-1:0] reg_bx,
  input  logic [ADDR_W-1:0] reg_bp,
  input  logic [ADDR_W-1:0] reg_si,
  input  logic [ADDR_W-1:0] reg_di,
  input  logic [ADDR_W-1:0] seg_es,
  input  logic [ADDR_W-1:0] seg_cs,
  input  logic [ADDR_W-1:0] seg_ss,
  input  logic [ADDR_W-1:0] seg_ds,
  output logic              out_valid,
  output logic [2:0]        out_reg_code,
  output logic              out_wide,
  output logic              out_reg_dst,
  output logic              out_rm_is_reg,
  output logic [2:0]        out_rm_code,
  output logic [ADDR_W-1:0] out_ea,
  output logic [1:0]        out_seg,
  output logic [PA_W-1:0]   out_pa
);
  localparam int EXT_W = ADDR_W - BYTE_W;

  st_t              st_q, st_d;
  logic             ovr_q;
  seg_t             ovr_seg_q;
  logic             dir_q, wide_q;
  logic [1:0]       mode_q;
  logic [2:0]       reg_q, rm_q;
  logic [BYTE_W-1:0] dlo_q;

  logic             is_prefix;
  logic [1:0]       cur_mode;
  logic [2:0]       cur_rm;
  logic             c_is_reg, c_use_base, c_base_bp, c_use_idx, c_idx_di;
  logic [1:0]       c_disp_n;
  seg_t             c_def_seg, sel_seg;
  logic             fin;
  logic [ADDR_W-1:0] disp_val, base_val, idx_val, seg_val, ea_val;
  logic [PA_W-1:0]  pa_val;

  assign is_prefix = (in_byte[7:5] == 3'b001) && (in_byte[2:0] == 3'b110);
  assign cur_mode  = (st_q == ST_MODRM) ? in_byte[7:6] : mode_q;
  assign cur_rm    = (st_q == ST_MODRM) ? in_byte[2:0] : rm_q;

  modrm_classify u_cls (
    .mode     (cur_mode),
    .rm       (cur_rm),
    .is_reg   (c_is_reg),
    .disp_n   (c_disp_n),
    .use_base (c_use_base),
    .base_bp  (c_base_bp),
    .use_idx  (c_use_idx),
    .idx_di   (c_idx_di),
    .def_seg  (c_def_seg)
  );

  always_comb begin
    base_val = c_use_base ? (c_base_bp ? reg_bp : reg_bx) : '0;
    idx_val  = c_use_idx  ? (c_idx_di  ? reg_di : reg_si) : '0;
    sel_seg  = ovr_q ? ovr_seg_q : c_def_seg;
    unique case (sel_seg)
      SEG_ES:  seg_val = seg_es;
      SEG_CS:  seg_val = seg_cs;
      SEG_SS:  seg_val = seg_ss;
      default: seg_val = seg_ds;
    endcase
  end

  // finishing byte and displacement value seen this cycle
  always_comb begin
    fin      = 1'b0;
    disp_val = '0;
    if (in_valid) begin
      unique case (st_q)
        ST_MODRM: fin = (c_disp_n == 2'd0);
        ST_DLO: begin
          fin      = (c_disp_n == 2'd1);
          disp_val = {{EXT_W{in_byte[BYTE_W-1]}}, in_byte};
        end
        ST_DHI: begin
          fin      = 1'b1;
          disp_val = {in_byte, dlo_q};
        end
        default: fin = 1'b0;
      endcase
    end
  end

  modrm_ea_adder #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_add (
    .base     (base_val),
    .index    (idx_val),
    .disp     (disp_val),
    .seg_base (seg_val),
    .ea       (ea_val),
    .pa       (pa_val)
  );

  always_comb begin
    st_d = st_q;
    if (in_valid) begin
      unique case (st_q)
        ST_OPC:   if (!is_prefix) st_d = ST_MODRM;
        ST_MODRM: st_d = (c_disp_n == 2'd0) ? ST_OPC : ST_DLO;
        ST_DLO:   st_d = (c_disp_n == 2'd2) ? ST_DHI : ST_OPC;
        default:  st_d = ST_OPC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_OPC;
      ovr_q         <= 1'b0;
      ovr_seg_q     <= SEG_DS;
      dir_q         <= 1'b0;
      wide_q        <= 1'b0;
      mode_q        <= '0;
      reg_q         <= '0;
      rm_q          <= '0;
      dlo_q         <= '0;
      out_valid     <= 1'b0;
      out_reg_code  <= '0;
      out_wide      <= 1'b0;
      out_reg_dst   <= 1'b0;
      out_rm_is_reg <= 1'b0;
      out_rm_code   <= '0;
      out_ea        <= '0;
      out_seg       <= '0;
      out_pa        <= '0;
    end else begin
      st_q      <= st_d;
      out_valid <= fin;
      if (in_valid) begin
        unique case (st_q)
          ST_OPC: begin
            if (is_prefix) begin
              ovr_q     <= 1'b1;
              ovr_seg_q <= seg_t'(in_byte[4:3]);
            end else begin
              dir_q  <= in_byte[1];
              wide_q <= in_byte[0];
            end
          end
          ST_MODRM: begin
            mode_q <= in_byte[7:6];
            reg_q  <= in_byte[5:3];
            rm_q   <= in_byte[2:0];
          end
          ST_DLO:  dlo_q <= in_byte;
          default: ;
        endcase
      end
      if (fin) begin
        ovr_q         <= 1'b0;
        out_reg_code  <= (st_q == ST_MODRM) ? in_byte[5:3] : reg_q;
        out_wide      <= wide_q;
        out_reg_dst   <= dir_q;
        out_rm_is_reg <= c_is_reg;
        out_rm_code   <= cur_rm;
        out_ea        <= c_is_reg ? '0 : ea_val;
        out_pa        <= c_is_reg ? '0 : pa_val;
        out_seg       <= sel_seg;
      end
    end
  end
endmodule

// File: rtl/modrm_agu_chk.sv
module modrm_agu_chk #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = ADDR_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] seg_es,
  input logic [ADDR_W-1:0] seg_cs,
  input logic [ADDR_W-1:0] seg_ss,
  input logic [ADDR_W-1:0] seg_ds,
  input logic              out_valid,
  input logic              out_rm_is_reg,
  input logic [ADDR_W-1:0] out_ea,
  input logic [1:0]        out_seg,
  input logic [PA_W-1:0]   out_pa
);
  logic [ADDR_W-1:0] es_q, cs_q, ss_q, ds_q, sel_q;

  always_ff @(posedge clk) begin
    es_q <= seg_es;
    cs_q <= seg_cs;
    ss_q <= seg_ss;
    ds_q <= seg_ds;
  end

  always_comb begin
    unique case (out_seg)
      2'b00:   sel_q = es_q;
      2'b01:   sel_q = cs_q;
      2'b10:   sel_q = ss_q;
      default: sel_q = ds_q;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R9

  AST_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R9

  AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rm_is_reg) |-> (out_ea == '0 && out_pa == '0)); // R4

  AST_PA_SUM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_rm_is_reg) |->
      out_pa == ({sel_q, {SEG_SHIFT{1'b0}}} + PA_W'(out_ea))); // R8
endmodule

bind modrm_agu modrm_agu_chk #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .seg_es        (seg_es),
  .seg_cs        (seg_cs),
  .seg_ss        (seg_ss),
  .seg_ds        (seg_ds),
  .out_valid     (out_valid),
  .out_rm_is_reg (out_rm_is_reg),
  .out_ea        (out_ea),
  .out_seg       (out_seg),
  .out_pa        (out_pa)
);

// File: tb/modrm_agu_test.sv
module modrm_agu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        out_valid, out_wide, out_reg_dst, out_rm_is_reg;
  logic [2:0]  out_reg_code, out_rm_code;
  logic [15:0] out_ea;
  logic [1:0]  out_seg;
  logic [19:0] out_pa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  modrm_agu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .out_reg_code(out_reg_code), .out_wide(out_wide),
    .out_reg_dst(out_reg_dst), .out_rm_is_reg(out_rm_is_reg),
    .out_rm_code(out_rm_code), .out_ea(out_ea), .out_seg(out_seg),
    .out_pa(out_pa)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one byte at a falling edge; return at the next falling edge
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'hxx;
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R9 idle cycle quiet", {31'd0, out_valid}, 32'd0);
  endtask

  // o: 0 no prefix, 1..4 prefix with segment o-1
  task automatic run_instr(input int o, input logic [7:0] opc, input logic [7:0] mrm,
                           input logic [7:0] lo, input logic [7:0] hi, input bit gap);
    logic [1:0]  md;
    logic [2:0]  rm;
    int          nd;
    logic [15:0] b, x, d, ea;
    logic [15:0] sv;
    logic [1:0]  sg;
    logic [19:0] pa;
    bit          bp_used;
    md = mrm[7:6];
    rm = mrm[2:0];
    nd = (md == 2'b01) ? 1 : (md == 2'b10) ? 2 : (md == 2'b00 && rm == 3'b110) ? 2 : 0;
    b = '0; x = '0; bp_used = 1'b0;
    case (rm)
      3'd0: begin b = reg_bx; x = reg_si; end
      3'd1: begin b = reg_bx; x = reg_di; end
      3'd2: begin b = reg_bp; x = reg_si; bp_used = 1'b1; end
      3'd3: begin b = reg_bp; x = reg_di; bp_used = 1'b1; end
      3'd4: x = reg_si;
      3'd5: x = reg_di;
      3'd6: if (md != 2'b00) begin b = reg_bp; bp_used = 1'b1; end
      default: b = reg_bx;
    endcase
    d = (nd == 1) ? {{8{lo[7]}}, lo} : (nd == 2) ? {hi, lo} : 16'h0000;
    ea = b + x + d;
    sg = (o != 0) ? 2'(o - 1) : (bp_used ? 2'b10 : 2'b11);
    case (sg)
      2'b00: sv = seg_es;
      2'b01: sv = seg_cs;
      2'b10: sv = seg_ss;
      default: sv = seg_ds;
    endcase
    pa = {sv, 4'h0} + {4'h0, ea};

    if (o != 0) begin
      send({3'b001, 2'(o - 1), 3'b110});
      chk("R2 prefix no result", {31'd0, out_valid}, 32'd0);
    end
    send(opc);
    chk("R9 opcode no result", {31'd0, out_valid}, 32'd0);
    if (gap) idle();
    send(mrm);
    if (nd >= 1) begin
      chk("R6 awaiting disp", {31'd0, out_valid}, 32'd0);
      if (gap) idle();
      send(lo);
    end
    if (nd == 2) begin
      chk("R6 awaiting disp high", {31'd0, out_valid}, 32'd0);
      send(hi);
    end
    chk("R9 result strobe", {31'd0, out_valid}, 32'd1);
    chk("R3 reg code", {29'd0, out_reg_code}, {29'd0, mrm[5:3]});
    chk("R3 width/dir", {30'd0, out_wide, out_reg_dst}, {30'd0, opc[0], opc[1]});
    if (md == 2'b11) begin
      chk("R4 reg operand", {28'd0, out_rm_is_reg, out_rm_code}, {28'd0, 1'b1, rm});
      chk("R4 no address", {12'd0, out_pa}, 32'd0);
    end else begin
      chk("R4 memory flag", {31'd0, out_rm_is_reg}, 32'd0);
      chk("R5 R6 effective address", {16'd0, out_ea}, {16'd0, ea});
      chk("R7 R2 segment", {30'd0, out_seg}, {30'd0, sg});
      chk("R8 physical address", {12'd0, out_pa}, {12'd0, pa});
    end
    @(negedge clk);
    chk("R9 single pulse", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset strobe", {31'd0, out_valid}, 32'd0);
    chk("R1 after reset pa/ea", {12'd0, out_pa} | {16'd0, out_ea}, 32'd0);

    // worked example: data seg 3000h, BX 0200h, SI 1000h, disp 08h
    seg_ds = 16'h3000; reg_bx = 16'h0200; reg_si = 16'h1000;
    seg_ss = 16'h5000; seg_es = 16'h0100; seg_cs = 16'h0200;
    run_instr(0, 8'h88, 8'b01_001_000, 8'h08, 8'h00, 1'b0);
    chk("R8 example pa", {12'd0, out_pa}, 32'h31208);

    // R10: prefix applies once, then default returns
    run_instr(3, 8'h8B, 8'b00_010_111, 8'h00, 8'h00, 1'b0);
    run_instr(0, 8'h8B, 8'b00_010_111, 8'h00, 8'h00, 1'b0);
    chk("R10 default after override", {30'd0, out_seg}, 32'd3);

    // sweep every mode byte under no prefix and each prefix
    for (int o = 0; o < 5; o++) begin
      for (int m = 0; m < 256; m++) begin
        reg_bx = 16'(32'h0200 + m * 32'h0101);
        reg_bp = 16'(32'hFF00 + m * 32'h0013);
        reg_si = 16'(32'h1000 + m * 32'h0231);
        reg_di = 16'(32'hE000 + m * 32'h0107);
        seg_es = 16'h1000;
        seg_cs = 16'(32'h2000 + o);
        seg_ss = 16'(32'hA000 + m);
        seg_ds = 16'hF800;
        run_instr(o, {6'b100010, 1'(m ^ o), 1'(m >> 1)}, 8'(m),
                  8'(m * 5 + o), ~8'(m), (m % 4) == 1);
      end
    end
    done = 1'b1;
    finish_run();
  end
endmodule